// File: doc/BRIEF.md
# Sync-Phased Clock Channel Divider

This block divides a clock by any whole number from 1 to 1024 and gives the result a 50% duty cycle, even for odd ratios. It runs on a tick clock at twice the rate of the clock being divided, so one tick is one half-period of that input clock. Each time a sync request is released, the divider can delay the start of its output by 0 to 63 ticks, which is 0 to 31.5 input periods in half-period steps.

Two configuration bytes set the divide value and the starting phase. The divide field holds the ratio minus one. Its low eight bits are the whole of the low byte, and its two top bits are bits [1:0] of the high byte. Bits [7:2] of the high byte hold the phase. The block takes in new configuration only while sync or reset is asserted. The output is a registered level that changes only on tick clock rising edges.

Top module: `chan_divider`

## Requirements
- R1: With field value N = {cfg_hi[1:0], cfg_lo}, the output period is exactly 2*(N+1) ticks, which is a division by N+1 (N=0 divides by 1, N=1023 divides by 1024).
- R2: The 10-bit divide field takes bits [9:8] from cfg_hi[1:0] and bits [7:0] from cfg_lo.
- R3: The phase value P comes from cfg_hi[7:2] and runs from 0 to 63.
- R4: Tick 0 is the first rising edge of clk at which sync and rst are both sampled low. clk_out first goes high on the edge at tick P, so each unit of P delays the first rising edge by one tick.
- R5: The high time and the low time are each N+1 ticks. With N=0 the output toggles on every tick.
- R6: On every edge at which sync is sampled high, clk_out is driven low and the counters return to their preload state.
- R7: Changes to cfg_lo or cfg_hi while sync and rst are low have no effect on the output.
- R8: An edge with rst high acts like a sync: clk_out goes low and the configuration is loaded.
- R9: After the phase delay the waveform repeats every 2*(N+1) ticks without drift, including when P is larger than one output period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, two ticks per divider input period |
| rst | input | 1 | Synchronous reset, active high; loads the configuration |
| sync | input | 1 | Sync request, active high; holds the output low while asserted |
| cfg_lo | input | 8 | Divide field bits [7:0] |
| cfg_hi | input | 8 | Phase in [7:2], divide field bits [9:8] in [1:0] |
| clk_out | output | 1 | Divided clock, registered level |

## Verification
The assertions assume the configuration is loaded only while sync or rst is high. They therefore take the timing and phase reference from the bytes present on the last hold edge. They also assume rst is asserted before the first clock edge. The bench changes the configuration bytes only on falling clock edges, either while holding sync or as a deliberate test of R7. It keeps rst high from time zero, so every measured edge position refers to a known release edge.

// File: rtl/chan_divider.sv
module chan_divider (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync,
  input  logic [7:0] cfg_lo,
  input  logic [7:0] cfg_hi,
  output logic       clk_out
);
  localparam int DIV_W = 10;
  localparam int PH_W  = 6;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic [PH_W-1:0]  dly;

  wire hold = rst | sync;

  always_ff @(posedge clk) begin
    if (hold) begin
      div_q   <= {cfg_hi[1:0], cfg_lo};
      dly     <= cfg_hi[7:2];
      cnt     <= '0;
      clk_out <= 1'b0;
    end else if (dly != '0) begin
      dly <= dly - 1'b1;
    end else if (cnt == '0) begin
      clk_out <= ~clk_out;
      cnt     <= div_q;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/chan_divider_chk.sv
module chan_divider_chk (
  input logic       clk,
  input logic       rst,
  input logic       sync,
  input logic [7:0] cfg_lo,
  input logic [7:0] cfg_hi,
  input logic       clk_out
);
  logic [9:0]  n_c;
  logic [5:0]  p_c;
  logic [10:0] gap;
  logic [6:0]  since;
  logic        armed;
  logic        prev;
  logic        rst_d = 1'b0;

  wire chg = (clk_out != prev);

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst || sync) begin
      n_c   <= {cfg_hi[1:0], cfg_lo};
      p_c   <= cfg_hi[7:2];
      gap   <= '0;
      since <= '0;
      armed <= 1'b0;
      prev  <= 1'b0;
    end else begin
      prev <= clk_out;
      if (chg) begin
        gap   <= 11'd1;
        armed <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
      if (since != '1) since <= since + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (rst_d === 1'b1) assert_reset_low_R8: assert (clk_out == 1'b0);
  end

  assert_sync_low_R6: assert property (@(posedge clk) disable iff (rst)
    sync |=> !clk_out);

  assert_half_period_R5: assert property (@(posedge clk) disable iff (rst || sync)
    (armed && chg) |-> (gap == {1'b0, n_c} + 11'd1));

  assert_first_rise_R4: assert property (@(posedge clk) disable iff (rst || sync)
    (!armed && chg) |-> (clk_out && since == {1'b0, p_c} + 7'd1));
endmodule

bind chan_divider chan_divider_chk u_chk (
  .clk(clk), .rst(rst), .sync(sync),
  .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .clk_out(clk_out)
);

// File: tb/chan_divider_test.sv
module chan_divider_test;
  localparam int TCK = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync = 1'b0;
  logic [7:0] cfg_lo = '0;
  logic [7:0] cfg_hi = '0;
  logic       clk_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  chan_divider uut (.clk(clk), .rst(rst), .sync(sync),
                    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .clk_out(clk_out));

  function automatic logic expect_at(int n, int p, int j);
    int m;
    if (j < p) return 1'b0;
    m = (j - p) % (2 * (n + 1));
    return (m < n + 1);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load(int n, int p);
    @(negedge clk);
    cfg_lo = n[7:0];
    cfg_hi = {p[5:0], n[9:8]};
    sync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sync = 1'b0;
  endtask

  task automatic measure(int n, int p, int j0, int len, string req);
    int bad = 0;
    for (int j = j0; j < j0 + len; j++) begin
      @(negedge clk);
      if (clk_out !== expect_at(n, p, j)) begin
        if (bad == 0)
          $display("FAIL %s n=%0d p=%0d tick=%0d actual=%b expected=%b",
                   req, n, p, j, clk_out, expect_at(n, p, j));
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic run_case(int n, int p, string req);
    load(n, p);
    measure(n, p, 0, p + 4 * (n + 1) + 3, req);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    check("R8 reset output", clk_out, 1'b0);
    rst = 1'b0;
  endtask

  task automatic test_sync_hold();
    load(2, 0);
    measure(2, 0, 0, 7, "R6 pre");
    sync = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 0 || k == 11) check("R6 held low", clk_out, 1'b0);
    end
    sync = 1'b0;
    measure(2, 0, 0, 12, "R6 restart");
  endtask

  task automatic test_cfg_ignored();
    load(3, 2);
    measure(3, 2, 0, 9, "R7 before");
    cfg_lo = 8'd9;
    cfg_hi = {6'd5, 2'b01};
    measure(3, 2, 9, 30, "R7 change ignored");
  endtask

  task automatic test_reset_reload();
    load(5, 0);
    measure(5, 0, 0, 4, "R8 pre");
    cfg_lo = 8'd2;
    cfg_hi = {6'd3, 2'b00};
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset drives low", clk_out, 1'b0);
    rst = 1'b0;
    measure(2, 3, 0, 20, "R8 reload");
  endtask

  initial begin
    #(TCK * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset_state();
    run_case(0, 0, "R5 divide-by-1 toggles each tick");
    run_case(0, 1, "R4 phase 1");
    run_case(0, 63, "R4 phase 63");
    run_case(1023, 0, "R1 divide-by-1024");
    run_case(1023, 63, "R1 R4 divide-by-1024 phase 63");
    run_case(2, 1, "R5 odd ratio duty");
    run_case(256, 0, "R2 upper field bit 8");
    run_case(512, 7, "R2 upper field bit 9");
    run_case(4, 42, "R3 phase field");
    run_case(2, 63, "R9 phase beyond period");
    run_case(1, 1, "R9 short period");
    test_sync_hold();
    test_cfg_ignored();
    test_reset_reload();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule